// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor port and a word-wide main-memory port and keeps a direct-mapped copy of recently used memory blocks. Every CPU word address is split into three fields. The low bits pick a word inside a block, the middle bits pick one cache entry, and the remaining high bits form the tag. The tag is compared with the one stored for that entry. A hit finishes in one clock. A miss holds the CPU off. If the resident block was modified, the controller first streams it back to memory one word per beat. It then fetches the requested block the same way, and finally completes the original read or write.

The CPU starts an access by raising a one-cycle strobe together with the address, the direction and the write data. The controller answers with a one-cycle data-ready pulse. Read data is valid while that pulse is high. While a miss is being handled, a busy line is high and new strobes are ignored. The memory side uses a request/ready beat handshake. Each beat moves one 32-bit word, and the word addresses increase through the block.

The entry count and the words per block are parameters. Both must be powers of two, and each must be at least 2.

Top module: `cache_wb_top`

## Requirements
- R1: After reset, busy, data-ready and memory request are all low, and every entry is invalid, so the first access to any entry is a miss.
- R2: The address bits, from low to high, are: word offset (log2 WORDS bits), entry index (log2 ENTRIES bits), and tag (the rest). Memory addresses are word addresses of the same width, and every transfer covers a whole block at a block-aligned start address.
- R3: A read hit raises data-ready with the addressed word in the clock after the strobe. Busy stays low and the memory port stays idle.
- R4: A write hit stores the word and marks the entry dirty, with no memory traffic. A read hit leaves the dirty state as it was.
- R5: A miss on an invalid or clean entry produces only a refill: WORDS read beats at {new tag, index, 0..WORDS-1}, in increasing order.
- R6: A miss on a dirty entry first writes back WORDS beats at {stored tag, index, 0..WORDS-1}, carrying the cached words. Only after that does it refill, and memory then holds the modified data.
- R7: Busy is high from the clock after a missing strobe until completion. It falls in the same clock that data-ready pulses. A strobe raised while busy is high is ignored, and the memory port requests only while busy.
- R8: On a write miss, the block is refilled, then the word is written. The entry is left valid and dirty.
- R9: Two addresses with the same index and different tags miss on every alternation.
- R10: A memory beat completes only in a cycle where request and ready are both high. Until then, the address and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_as | input | 1 | Access strobe, one cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_busy | output | 1 | Miss in progress |
| cpu_ready | output | 1 | Access completed, one-cycle pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data |
| mem_ready | input | 1 | Beat accepted in this cycle |

## Verification
The bench builds the controller with an 8-bit address, 4 entries and 4-word blocks. The tag is then 4 bits, so ping-pong pairs such as 0x00/0x40 are easy to form. All 256 memory words can be modelled and compared at the end. Over a short run, the random traffic touches every entry many times through all four cases: clean miss, dirty miss, read hit and write hit. The memory responder stalls at random, which exercises beat holding and a strobe injected during busy.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_FINISH
    } ctl_state_t;

    function automatic ctl_state_t miss_entry_state(input logic valid, input logic dirty);
        return (valid && dirty) ? ST_EVICT : ST_FILL;
    endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 9,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty
);
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (fill) begin
            tag_q[idx] <= fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (mark_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store
    import cache_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WORDS   = 8,
    localparam int DEPTH  = ENTRIES * WORDS,
    localparam int A_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [A_W-1:0]    raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic              we,
    input  logic [A_W-1:0]    waddr,
    input  logic [WORD_W-1:0] wdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ENTRIES = 16,
    parameter int WORDS   = 8,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_as,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    cpu_busy,
    output logic                    cpu_ready,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    input  logic [WORD_W-1:0]       mem_rdata,
    input  logic                    mem_ready,
    output logic [IDX_W-1:0]        ts_idx,
    output logic                    ts_fill,
    output logic [TAG_W-1:0]        ts_fill_tag,
    output logic                    ts_mark_dirty,
    input  logic [TAG_W-1:0]        ts_tag,
    input  logic                    ts_valid,
    input  logic                    ts_dirty,
    output logic [IDX_W+OFF_W-1:0]  ds_raddr,
    input  logic [WORD_W-1:0]       ds_rdata,
    output logic                    ds_we,
    output logic [IDX_W+OFF_W-1:0]  ds_waddr,
    output logic [WORD_W-1:0]       ds_wdata
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } word_addr_t;

    typedef struct packed {
        logic              we;
        word_addr_t        addr;
        logic [WORD_W-1:0] wdata;
    } cpu_req_t;

    ctl_state_t        state_q, state_d;
    cpu_req_t          req_q;
    word_addr_t        in_addr;
    logic [OFF_W-1:0]  beat_q;
    logic [WORD_W-1:0] rdata_q;
    logic              ready_q;
    logic              lookup_hit;
    logic              beat_done;
    logic              beat_final;

    assign in_addr    = cpu_addr;
    assign ts_idx     = (state_q == ST_IDLE) ? in_addr.idx : req_q.addr.idx;
    assign lookup_hit = ts_valid && (ts_tag == in_addr.tag);
    assign beat_done  = mem_req && mem_ready;
    assign beat_final = (beat_q == OFF_W'(WORDS - 1));
    assign ts_fill_tag = req_q.addr.tag;

    always_comb begin
        state_d       = state_q;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = '0;
        mem_wdata     = '0;
        ts_fill       = 1'b0;
        ts_mark_dirty = 1'b0;
        ds_raddr      = {req_q.addr.idx, req_q.addr.off};
        ds_we         = 1'b0;
        ds_waddr      = {req_q.addr.idx, req_q.addr.off};
        ds_wdata      = req_q.wdata;
        case (state_q)
            ST_IDLE: begin
                ds_raddr = {in_addr.idx, in_addr.off};
                if (cpu_as) begin
                    if (lookup_hit) begin
                        if (cpu_we) begin
                            ds_we         = 1'b1;
                            ds_waddr      = {in_addr.idx, in_addr.off};
                            ds_wdata      = cpu_wdata;
                            ts_mark_dirty = 1'b1;
                        end
                    end else begin
                        state_d = miss_entry_state(ts_valid, ts_dirty);
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ts_tag, req_q.addr.idx, beat_q};
                ds_raddr  = {req_q.addr.idx, beat_q};
                mem_wdata = ds_rdata;
                if (beat_done && beat_final) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_q.addr.tag, req_q.addr.idx, beat_q};
                if (beat_done) begin
                    ds_we    = 1'b1;
                    ds_waddr = {req_q.addr.idx, beat_q};
                    ds_wdata = mem_rdata;
                    if (beat_final) begin
                        ts_fill = 1'b1;
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_FINISH: begin
                if (req_q.we) begin
                    ds_we         = 1'b1;
                    ts_mark_dirty = 1'b1;
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            ready_q <= 1'b0;
            rdata_q <= '0;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            ready_q <= 1'b0;
            if (beat_done) begin
                beat_q <= beat_q + 1'b1;
            end
            if (state_q == ST_IDLE && cpu_as) begin
                req_q <= '{we: cpu_we, addr: in_addr, wdata: cpu_wdata};
                if (lookup_hit) begin
                    ready_q <= 1'b1;
                    if (!cpu_we) begin
                        rdata_q <= ds_rdata;
                    end
                end
            end
            if (state_q == ST_FINISH) begin
                ready_q <= 1'b1;
                if (!req_q.we) begin
                    rdata_q <= ds_rdata;
                end
            end
        end
    end

    assign cpu_busy  = (state_q != ST_IDLE);
    assign cpu_ready = ready_q;
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cache_wb_top.sv
module cache_wb_top
    import cache_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ENTRIES = 16,
    parameter int WORDS   = 8,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_as,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_busy,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready
);
    logic [IDX_W-1:0]       ts_idx;
    logic                   ts_fill;
    logic [TAG_W-1:0]       ts_fill_tag;
    logic                   ts_mark_dirty;
    logic [TAG_W-1:0]       ts_tag;
    logic                   ts_valid;
    logic                   ts_dirty;
    logic [IDX_W+OFF_W-1:0] ds_raddr;
    logic [WORD_W-1:0]      ds_rdata;
    logic                   ds_we;
    logic [IDX_W+OFF_W-1:0] ds_waddr;
    logic [WORD_W-1:0]      ds_wdata;

    cache_ctrl #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .WORDS(WORDS)) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_as(cpu_as), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ts_idx(ts_idx), .ts_fill(ts_fill), .ts_fill_tag(ts_fill_tag),
        .ts_mark_dirty(ts_mark_dirty), .ts_tag(ts_tag), .ts_valid(ts_valid),
        .ts_dirty(ts_dirty),
        .ds_raddr(ds_raddr), .ds_rdata(ds_rdata), .ds_we(ds_we),
        .ds_waddr(ds_waddr), .ds_wdata(ds_wdata)
    );

    cache_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .idx(ts_idx), .fill(ts_fill), .fill_tag(ts_fill_tag),
        .mark_dirty(ts_mark_dirty), .rd_tag(ts_tag), .rd_valid(ts_valid),
        .rd_dirty(ts_dirty)
    );

    cache_data_store #(.ENTRIES(ENTRIES), .WORDS(WORDS)) u_data (
        .clk(clk), .raddr(ds_raddr), .rdata(ds_rdata), .we(ds_we),
        .waddr(ds_waddr), .wdata(ds_wdata)
    );
endmodule

// File: rtl/cache_wb_checker.sv
module cache_wb_checker #(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_busy,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!cpu_busy && !cpu_ready && !mem_req));

    p_req_within_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_busy);

    p_ready_not_busy_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !cpu_busy);

    p_busy_end_ready_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_busy) |-> cpu_ready);

    p_beat_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_beat_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && (mem_addr[OFF_W-1:0] != OFF_W'(WORDS - 1)))
        |=> (mem_req && (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))));

    p_evict_before_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !(mem_req && mem_we));
endmodule

bind cache_wb_top cache_wb_checker #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
    .clk(clk), .rst(rst), .cpu_busy(cpu_busy), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/sim_cache_wb_top.sv
`timescale 1ns/1ps
module sim_cache_wb_top;
    localparam int AW = 8;
    localparam int NE = 4;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          cpu_as = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic [31:0]   cpu_rdata;
    logic          cpu_busy, cpu_ready;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ready = 1'b0;

    cache_wb_top #(.ADDR_W(AW), .ENTRIES(NE), .WORDS(NW)) u0 (
        .clk(clk), .rst(rst), .cpu_as(cpu_as), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [31:0]   data;
    } beat_t;

    int          checks = 0;
    int          failures = 0;
    logic [31:0] env_mem [256];
    logic [31:0] ref_mem [256];
    logic [31:0] m_data [NE][NW];
    logic [3:0]  m_tag [NE];
    bit          m_v [NE];
    bit          m_d [NE];
    beat_t       got_q [$];
    beat_t       exp_q [$];
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] rnd  = 16'h1D2B;
    bit          prev_stall = 0;
    logic [AW-1:0] held_addr = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder with random stalls
    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            prev_stall = 0;
        end else begin
            if (mem_req && !cpu_busy)
                chk(0, "R7", "memory request outside busy", 32'(mem_req), 32'h0);
            if (prev_stall && mem_req)
                chk(mem_addr == held_addr, "R10", "address held through stall",
                    32'(mem_addr), 32'(held_addr));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = mem_req && (lfsr[1:0] != 2'b00);
            mem_rdata = env_mem[mem_addr];
            if (mem_req && mem_ready) begin
                got_q.push_back('{we: mem_we, addr: mem_addr, data: mem_we ? mem_wdata : env_mem[mem_addr]});
                if (mem_we) env_mem[mem_addr] = mem_wdata;
            end
            prev_stall = mem_req && !mem_ready;
            held_addr = mem_addr;
        end
    end

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [31:0] wd,
                          input bit poke, input string rq);
        logic [1:0] idx;
        logic [3:0] tag;
        logic [1:0] off;
        bit hit;
        logic [31:0] exp_rd;
        beat_t b;
        idx = a[3:2];
        tag = a[7:4];
        off = a[1:0];
        hit = m_v[idx] && (m_tag[idx] == tag);
        exp_q.delete();
        got_q.delete();
        if (!hit) begin
            if (m_v[idx] && m_d[idx]) begin
                for (int k = 0; k < NW; k++) begin
                    b = '{we: 1'b1, addr: {m_tag[idx], idx, 2'(k)}, data: m_data[idx][k]};
                    exp_q.push_back(b);
                    ref_mem[b.addr] = b.data;
                end
            end
            for (int k = 0; k < NW; k++) begin
                b = '{we: 1'b0, addr: {tag, idx, 2'(k)}, data: ref_mem[{tag, idx, 2'(k)}]};
                exp_q.push_back(b);
                m_data[idx][k] = b.data;
            end
            m_tag[idx] = tag;
            m_v[idx] = 1;
            m_d[idx] = 0;
        end
        if (we) begin
            m_data[idx][off] = wd;
            m_d[idx] = 1;
        end
        exp_rd = m_data[idx][off];

        @(negedge clk);
        cpu_as = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_as = 1'b0;
        if (hit) begin
            chk(cpu_ready && !cpu_busy, rq, "hit completes next cycle (R3)",
                {30'h0, cpu_busy, cpu_ready}, 32'h1);
        end else begin
            int n = 0;
            bit bad = 0;
            while (!cpu_ready && n < 2000) begin
                if (!cpu_busy) bad = 1;
                cpu_as = poke && (n == 1);
                cpu_addr = a ^ 8'hF0;
                cpu_we = ~we;
                n++;
                @(negedge clk);
            end
            cpu_as = 1'b0;
            chk(!bad, "R7", "busy held during miss", 32'(bad), 32'h0);
            chk(cpu_ready && !cpu_busy, "R7", "busy falls with ready",
                {30'h0, cpu_busy, cpu_ready}, 32'h1);
        end
        if (!we)
            chk(cpu_rdata == exp_rd, rq, "read data", cpu_rdata, exp_rd);
        chk(got_q.size() == exp_q.size(), rq, "memory beat count",
            32'(got_q.size()), 32'(exp_q.size()));
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
            chk(got_q[k] == exp_q[k], rq, "memory beat", {got_q[k].addr, 23'h0, got_q[k].we},
                {exp_q[k].addr, 23'h0, exp_q[k].we});
        if (poke) begin
            @(negedge clk);
            chk(!cpu_ready && !cpu_busy && !mem_req, "R7", "strobe during busy ignored",
                {29'h0, mem_req, cpu_busy, cpu_ready}, 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            env_mem[i] = {16'h5A00 ^ 16'(i * 37), 8'hC3, 8'(i)};
            ref_mem[i] = env_mem[i];
        end
        for (int e = 0; e < NE; e++) begin
            m_v[e] = 0;
            m_d[e] = 0;
            m_tag[e] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_busy && !cpu_ready && !mem_req, "R1", "idle after reset",
            {29'h0, mem_req, cpu_busy, cpu_ready}, 32'h0);

        access(0, 8'h00, '0, 0, "R1");              // first touch misses, refill only (R5)
        access(0, 8'h01, '0, 0, "R3");              // read hit
        access(1, 8'h02, 32'h1111_2222, 0, "R4");   // write hit, dirty
        access(0, 8'h03, '0, 0, "R4");              // read hit keeps dirty
        access(0, 8'h40, '0, 0, "R6");              // dirty victim written back, then refill
        access(0, 8'h00, '0, 0, "R9");              // ping-pong back, clean victim (R5)
        access(1, 8'h45, 32'hDEAD_BEEF, 0, "R8");   // write miss on entry 1
        access(0, 8'h45, '0, 0, "R8");              // written word visible
        access(0, 8'h05, '0, 0, "R9");              // dirty ping-pong write-back (R6)
        access(1, 8'h9A, 32'h0BAD_F00D, 1, "R7");   // strobe injected while busy
        access(0, 8'h9A, '0, 0, "R2");

        for (int i = 0; i < 300; i++) begin
            rnd = {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
            access(rnd[0], {rnd[9:8], 2'b00, rnd[5:2]} ^ {2'b00, rnd[11:10], 4'h0},
                   {rnd, ~rnd}, 0, "R2");
        end

        begin
            int bad = 0;
            for (int i = 0; i < 256; i++)
                if (env_mem[i] !== ref_mem[i]) bad++;
            chk(bad == 0, "R6", "memory image after write-backs", 32'(bad), 32'h0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule